// File: doc/BRIEF.md
# Ethernet Transmit Padder with Inter-Frame Gap Timer

This block sits on the transmit side between a source of frame bytes and a 4-bit media-independent output. Bytes arrive on a valid/ready stream with a last flag. Each byte goes out as two nibbles, low nibble first, with a transmit strobe held high. When a frame ends, the block may add zero bytes to reach the minimum payload. It then appends the 32-bit frame check sequence. After that it holds the line idle for a programmable gap before the next frame may start. Preamble and start delimiter are not produced here.

A small configuration port with a write strobe loads three fields: the gap setting, the pad switch and the transmit switch. All three have non-zero reset values, so the block transmits with the standard gap and with padding straight out of reset. Clearing the transmit switch stops new frames from being taken. A frame already in progress still runs to its end.

Top module: `eth_tx_pad_ifg`

## Requirements
- R1: Out of reset the gap setting is 21, padding is on and transmit is on. Back-to-back frames are therefore separated by 24 idle cycles, and a 10-byte frame leaves as 64 bytes.
- R2: A cycle with `cfg_we_i` high loads the gap setting, the pad switch and the transmit switch from their inputs. The new values apply to later frames.
- R3: With padding on, a frame of 1 to 60 bytes is followed by zero bytes up to 60 bytes and then by the 4-byte check sequence, giving 64 bytes (128 nibbles).
- R4: Frames of 61, 62 or 63 bytes (and longer) get no pad bytes. They grow only by the 4-byte check sequence.
- R5: The check sequence is the reflected CRC-32 with polynomial 0xEDB88320 and initial value 0xFFFFFFFF, taken over the payload and pad bytes. Its complement is sent as 8 nibbles, least significant nibble first.
- R6: Each byte is sent low nibble then high nibble. `mii_txen_o` rises in the cycle after the first byte is accepted and stays high without a break until the last check nibble.
- R7: After the last check nibble, `mii_txen_o` stays low for at least gap+3 cycles. If the next frame's first byte is already waiting, the next frame starts after exactly gap+3 idle cycles.
- R8: While the transmit switch is 0 and no frame is in flight, `s_ready_o` and `mii_txen_o` stay low whatever the source presents.
- R9: Clearing the transmit switch during a frame lets that frame finish intact, payload and check sequence included.
- R10: With padding off, a short frame is sent at its own length plus the 4-byte check sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Nibble clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_ifg_i | input | 5 | Gap setting; idle cycles = value + 3 |
| cfg_pad_en_i | input | 1 | Pad switch |
| cfg_tx_en_i | input | 1 | Transmit switch |
| s_valid_i | input | 1 | Source byte valid |
| s_data_i | input | 8 | Source byte |
| s_last_i | input | 1 | Marks the final byte of a frame |
| s_ready_o | output | 1 | Block takes the byte this cycle |
| mii_txd_o | output | 4 | Transmit nibble |
| mii_txen_o | output | 1 | Transmit strobe |

## Verification
The bench targets the length boundary around 60 bytes: 1, 10, 60, 61, 62, 63 and 64 bytes with padding on, plus short frames with padding off. A design with an off-by-one pad limit or one that pads 61 to 63 byte frames would shift every following nibble and the check sequence. Back-to-back frames at gap settings 0, 21 and 31 measure the idle run exactly, which exposes a timer that starts one cycle late or leaves out the fixed offset of 3. The transmit switch is toggled both with the line idle and in the middle of a frame. A design that truncates the running frame would leave expected nibbles unconsumed, and one that ignores the switch would raise ready.

// File: rtl/eth_tx_pkg.sv
package eth_tx_pkg;

  localparam logic [31:0] CRC_POLY = 32'hEDB8_8320;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DATA,
    ST_PAD,
    ST_FCS,
    ST_GAP
  } tx_st_e;

  // reflected CRC-32, one byte
  function automatic logic [31:0] crc32_byte(logic [31:0] c, logic [7:0] d);
    logic [31:0] r;
    r = c ^ {24'h0, d};
    for (int i = 0; i < 8; i++) begin
      r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/eth_tx_cfg_regs.sv
module eth_tx_cfg_regs #(
  parameter int unsigned IFG_W   = 5,
  parameter int unsigned IFG_RST = 21
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IFG_W-1:0] ifg_i,
  input  logic             pad_en_i,
  input  logic             tx_en_i,
  output logic [IFG_W-1:0] ifg_o,
  output logic             pad_en_o,
  output logic             tx_en_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ifg_o    <= IFG_W'(IFG_RST);
      pad_en_o <= 1'b1;
      tx_en_o  <= 1'b1;
    end else if (we_i) begin
      ifg_o    <= ifg_i;
      pad_en_o <= pad_en_i;
      tx_en_o  <= tx_en_i;
    end
  end

endmodule

// File: rtl/eth_tx_crc.sv
module eth_tx_crc
  import eth_tx_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clear_i,
  input  logic        upd_i,
  input  logic [7:0]  byte_i,
  output logic [31:0] crc_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      crc_o <= '1;
    else if (clear_i) crc_o <= '1;
    else if (upd_i)   crc_o <= crc32_byte(crc_o, byte_i);
  end

  assert_crc_seed_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (crc_o == 32'hFFFF_FFFF));

endmodule

// File: rtl/eth_tx_gap_timer.sv
module eth_tx_gap_timer #(
  parameter int unsigned IFG_W    = 5,
  parameter int unsigned IFG_BASE = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [IFG_W-1:0] ifg_i,
  output logic             last_o
);

  localparam int unsigned MAX_GAP = (1 << IFG_W) - 1 + IFG_BASE;
  localparam int unsigned CW      = $clog2(MAX_GAP + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= CW'(ifg_i) + CW'(IFG_BASE);
    else if (cnt_q != '0)   cnt_q <= cnt_q - CW'(1);
  end

  assign last_o = (cnt_q == CW'(1));

  assert_gap_countdown_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0 && !load_i) |=> (cnt_q == $past(cnt_q) - CW'(1)));

endmodule

// File: rtl/eth_tx_framer.sv
module eth_tx_framer
  import eth_tx_pkg::*;
#(
  parameter int unsigned MIN_LEN = 60
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tx_en_i,
  input  logic        pad_en_i,
  input  logic        s_valid_i,
  input  logic [7:0]  s_data_i,
  input  logic        s_last_i,
  output logic        s_ready_o,
  input  logic [31:0] crc_i,
  input  logic        gap_last_i,
  output logic        crc_clr_o,
  output logic        crc_upd_o,
  output logic [7:0]  crc_byte_o,
  output logic        gap_load_o,
  output logic [3:0]  txd_o,
  output logic        txen_o
);

  localparam int unsigned CNTW    = $clog2(MIN_LEN + 1);
  localparam int unsigned FCS_NIB = 8;

  tx_st_e          st_q;
  logic            phase_q;
  logic [7:0]      byte_q;
  logic            last_q;
  logic [CNTW-1:0] cnt_q;
  logic [2:0]      fcs_idx_q;

  logic            accept;
  logic [CNTW-1:0] cnt_inc;
  logic            short_frame;
  logic [31:0]     fcs_w;

  assign s_ready_o = (tx_en_i && (st_q == ST_IDLE || (st_q == ST_GAP && gap_last_i)))
                   || (st_q == ST_DATA && phase_q && !last_q);
  assign accept      = s_valid_i && s_ready_o;
  assign cnt_inc     = (cnt_q == CNTW'(MIN_LEN)) ? cnt_q : cnt_q + CNTW'(1);
  assign short_frame = cnt_inc < CNTW'(MIN_LEN);
  assign fcs_w       = ~crc_i;

  assign crc_clr_o  = accept && (st_q == ST_IDLE || st_q == ST_GAP);
  assign crc_upd_o  = phase_q && (st_q == ST_DATA || st_q == ST_PAD);
  assign crc_byte_o = (st_q == ST_PAD) ? 8'h00 : byte_q;
  assign gap_load_o = (st_q == ST_FCS) && (fcs_idx_q == 3'(FCS_NIB - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      phase_q   <= 1'b0;
      byte_q    <= '0;
      last_q    <= 1'b0;
      cnt_q     <= '0;
      fcs_idx_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE, ST_GAP: begin
          if (accept) begin
            byte_q  <= s_data_i;
            last_q  <= s_last_i;
            cnt_q   <= '0;
            phase_q <= 1'b0;
            st_q    <= ST_DATA;
          end else if (st_q == ST_GAP && gap_last_i) begin
            st_q <= ST_IDLE;
          end
        end
        ST_DATA: begin
          if (!phase_q) begin
            phase_q <= 1'b1;
          end else begin
            cnt_q <= cnt_inc;
            if (!last_q) begin
              if (accept) begin
                byte_q  <= s_data_i;
                last_q  <= s_last_i;
                phase_q <= 1'b0;
              end
            end else begin
              phase_q   <= 1'b0;
              fcs_idx_q <= '0;
              st_q      <= (pad_en_i && short_frame) ? ST_PAD : ST_FCS;
            end
          end
        end
        ST_PAD: begin
          phase_q <= ~phase_q;
          if (phase_q) begin
            cnt_q <= cnt_inc;
            if (cnt_inc == CNTW'(MIN_LEN)) begin
              fcs_idx_q <= '0;
              st_q      <= ST_FCS;
            end
          end
        end
        ST_FCS: begin
          fcs_idx_q <= fcs_idx_q + 3'd1;
          if (fcs_idx_q == 3'(FCS_NIB - 1)) st_q <= ST_GAP;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    txen_o = 1'b0;
    txd_o  = 4'h0;
    unique case (st_q)
      ST_DATA: begin
        txen_o = 1'b1;
        txd_o  = phase_q ? byte_q[7:4] : byte_q[3:0];
      end
      ST_PAD: txen_o = 1'b1;
      ST_FCS: begin
        txen_o = 1'b1;
        txd_o  = fcs_w[{fcs_idx_q, 2'b00} +: 4];
      end
      default: ;
    endcase
  end

  assert_pad_floor_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_FCS && $past(st_q) == ST_PAD) |-> (cnt_q == CNTW'(MIN_LEN)));

  assert_fcs_close_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_FCS && fcs_idx_q == 3'(FCS_NIB - 1)) |=> (st_q == ST_GAP && !txen_o));

  assert_txen_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (txen_o && !gap_load_o) |=> txen_o);

  assert_no_start_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!txen_o && !tx_en_i) |=> !txen_o);

endmodule

// File: rtl/eth_tx_pad_ifg.sv
module eth_tx_pad_ifg #(
  parameter int unsigned IFG_W    = 5,
  parameter int unsigned IFG_RST  = 21,
  parameter int unsigned IFG_BASE = 3,
  parameter int unsigned MIN_LEN  = 60
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [IFG_W-1:0] cfg_ifg_i,
  input  logic             cfg_pad_en_i,
  input  logic             cfg_tx_en_i,
  input  logic             s_valid_i,
  input  logic [7:0]       s_data_i,
  input  logic             s_last_i,
  output logic             s_ready_o,
  output logic [3:0]       mii_txd_o,
  output logic             mii_txen_o
);

  logic [IFG_W-1:0] ifg_q;
  logic             pad_en_q;
  logic             tx_en_q;
  logic             crc_clr;
  logic             crc_upd;
  logic [7:0]       crc_byte;
  logic [31:0]      crc_val;
  logic             gap_load;
  logic             gap_last;

  eth_tx_cfg_regs #(.IFG_W(IFG_W), .IFG_RST(IFG_RST)) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (cfg_we_i),
    .ifg_i    (cfg_ifg_i),
    .pad_en_i (cfg_pad_en_i),
    .tx_en_i  (cfg_tx_en_i),
    .ifg_o    (ifg_q),
    .pad_en_o (pad_en_q),
    .tx_en_o  (tx_en_q)
  );

  eth_tx_crc u_crc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (crc_clr),
    .upd_i   (crc_upd),
    .byte_i  (crc_byte),
    .crc_o   (crc_val)
  );

  eth_tx_gap_timer #(.IFG_W(IFG_W), .IFG_BASE(IFG_BASE)) u_gap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (gap_load),
    .ifg_i  (ifg_q),
    .last_o (gap_last)
  );

  eth_tx_framer #(.MIN_LEN(MIN_LEN)) u_framer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tx_en_i    (tx_en_q),
    .pad_en_i   (pad_en_q),
    .s_valid_i  (s_valid_i),
    .s_data_i   (s_data_i),
    .s_last_i   (s_last_i),
    .s_ready_o  (s_ready_o),
    .crc_i      (crc_val),
    .gap_last_i (gap_last),
    .crc_clr_o  (crc_clr),
    .crc_upd_o  (crc_upd),
    .crc_byte_o (crc_byte),
    .gap_load_o (gap_load),
    .txd_o      (mii_txd_o),
    .txen_o     (mii_txen_o)
  );

endmodule

// File: tb/eth_tx_pad_ifg_tb_top.sv
module eth_tx_pad_ifg_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [4:0] cfg_ifg = 5'd0;
  logic       cfg_pad = 1'b1;
  logic       cfg_en = 1'b1;
  logic       s_valid = 1'b0;
  logic [7:0] s_data = 8'h00;
  logic       s_last = 1'b0;
  logic       s_ready;
  logic [3:0] txd;
  logic       txen;

  always #4 clk = ~clk;  // 125 MHz

  eth_tx_pad_ifg dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .cfg_we_i     (cfg_we),
    .cfg_ifg_i    (cfg_ifg),
    .cfg_pad_en_i (cfg_pad),
    .cfg_tx_en_i  (cfg_en),
    .s_valid_i    (s_valid),
    .s_data_i     (s_data),
    .s_last_i     (s_last),
    .s_ready_o    (s_ready),
    .mii_txd_o    (txd),
    .mii_txen_o   (txen)
  );

  typedef struct {
    logic [3:0] nib;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   gap_q[$];
  int   total = 0;
  int   bad = 0;
  int   ifg_m = 21;
  bit   done = 0;

  function automatic logic [31:0] ref_crc(logic [31:0] c, logic [7:0] d);
    logic fb;
    for (int i = 0; i < 8; i++) begin
      fb = c[0] ^ d[i];
      c  = c >> 1;
      if (fb) c = c ^ 32'hEDB8_8320;
    end
    return c;
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic cfg_write(int ifg, bit pad, bit en);
    @(negedge clk);
    cfg_we  = 1'b1;
    cfg_ifg = 5'(ifg);
    cfg_pad = pad;
    cfg_en  = en;
    @(negedge clk);
    cfg_we = 1'b0;
    ifg_m  = ifg;
  endtask

  // driver: pushes expected nibbles and gap, then streams the bytes
  task automatic send_frame(int len, int seed, bit pad, bit b2b, string tag);
    logic [7:0]  b[$];
    logic [31:0] c;
    logic [31:0] f;
    int          wl;
    for (int i = 0; i < len; i++) b.push_back(8'((seed * 31 + i * 13 + 5) ^ (i << 3)));
    wl = (pad && len < 60) ? 60 : len;
    c  = 32'hFFFF_FFFF;
    for (int i = 0; i < wl; i++) begin
      logic [7:0] v;
      v = (i < len) ? b[i] : 8'h00;
      c = ref_crc(c, v);
      exp_q.push_back('{v[3:0], tag});
      exp_q.push_back('{v[7:4], tag});
    end
    f = ~c;
    for (int k = 0; k < 8; k++) exp_q.push_back('{f[4*k +: 4], tag});
    gap_q.push_back(b2b ? ifg_m + 3 : 0);
    for (int i = 0; i < len; i++) begin
      s_valid = 1'b1;
      s_data  = b[i];
      s_last  = (i == len - 1);
      while (!s_ready) @(negedge clk);
      @(negedge clk);
    end
    s_valid = 1'b0;
    s_last  = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 2000 && exp_q.size() != 0; i++) @(negedge clk);
    repeat (40) @(negedge clk);
  endtask

  // monitor
  bit started = 0;
  int idle = 0;
  bit prev_txen = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (txen) begin
        if (!prev_txen) begin
          int g;
          if (gap_q.size() == 0) g = 0; else g = gap_q.pop_front();
          if (started && g != 0) check(idle == g, "R7", "idle cycles", idle, g);
          started = 1;
        end
        if (exp_q.size() == 0) begin
          check(0, "R6", "unexpected txen nibble", int'(txd), -1);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(txd == e.nib, e.tag, "nibble", int'(txd), int'(e.nib));
        end
        idle = 0;
      end else begin
        if (prev_txen) begin
          check(exp_q.size() == 0 || gap_q.size() != 0, "R6", "txen dropped mid-frame", 0, 1);
        end
        idle++;
      end
      prev_txen = txen;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog R6 actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(txen == 1'b0, "R1", "txen after reset", int'(txen), 0);
    check(s_ready == 1'b1, "R1", "ready after reset", int'(s_ready), 1);

    // R1/R3/R4/R7 defaults, pad boundaries
    send_frame(10, 1, 1, 0, "R3");
    send_frame(60, 2, 1, 1, "R3");
    send_frame(1, 3, 1, 1, "R3");
    send_frame(61, 4, 1, 1, "R4");
    send_frame(62, 5, 1, 1, "R4");
    send_frame(63, 6, 1, 1, "R4");
    send_frame(64, 7, 1, 1, "R5");
    drain();

    // R2: new gap settings
    cfg_write(0, 1, 1);
    send_frame(20, 8, 1, 0, "R2");
    send_frame(20, 9, 1, 1, "R2");
    drain();
    cfg_write(31, 1, 1);
    send_frame(12, 10, 1, 0, "R2");
    send_frame(70, 11, 1, 1, "R2");
    drain();

    // R10: pad off
    cfg_write(21, 0, 1);
    send_frame(5, 12, 0, 0, "R10");
    send_frame(1, 13, 0, 1, "R10");
    send_frame(59, 14, 0, 1, "R10");
    drain();

    // R8: transmit off while idle
    cfg_write(21, 1, 0);
    begin
      bit seen;
      seen = 0;
      s_valid = 1'b1;
      s_data  = 8'hA5;
      s_last  = 1'b1;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (s_ready || txen) seen = 1;
      end
      s_valid = 1'b0;
      s_last  = 1'b0;
      check(!seen, "R8", "ready or txen while disabled", int'(seen), 0);
    end
    cfg_write(21, 1, 1);
    send_frame(15, 15, 1, 0, "R8");
    drain();

    // R9: disable mid-frame
    fork
      send_frame(40, 16, 1, 0, "R9");
      begin
        repeat (12) @(negedge clk);
        cfg_write(21, 1, 0);
      end
    join
    drain();
    check(exp_q.size() == 0, "R9", "frame nibbles left", exp_q.size(), 0);
    begin
      bit seen;
      seen = 0;
      s_valid = 1'b1;
      s_last  = 1'b1;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (s_ready || txen) seen = 1;
      end
      s_valid = 1'b0;
      s_last  = 1'b0;
      check(!seen, "R9", "new frame after disable", int'(seen), 0);
    end
    cfg_write(21, 1, 1);
    send_frame(3, 17, 1, 0, "R6");
    drain();

    check(exp_q.size() == 0, "R6", "nibbles left at end", exp_q.size(), 0);
    check(gap_q.size() == 0, "R7", "frames not seen", gap_q.size(), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule